// File: doc/BRIEF.md
# Per-Channel Control Bit Serializer

This block drives one serial control line on a time-division switch. Every connection-memory entry carries one control bit. Once per frame, the block sends out one bit for each pair of output stream and channel. It keeps its own copy of the 8 x 32 control bits. The write path of the connection memory updates that copy. An external timing generator supplies a bit tick, the current channel number and the current bit slot within the channel.

During each channel period, the block sends the eight bits that belong to the next channel. It sends one bit per bit period, stream 0 first and stream 7 last. Circuitry that acts on the line therefore gets one full channel of lead time. During channel 31 the block sends the bits for channel 0, so the look-ahead wraps across the frame boundary.

Writes first land in a pending image. A live image supplies the serial line. The pending image is copied into the live image once per frame, at the end of channel 30. The next output frame then starts at channel 31, carrying the channel 0 bits, and uses one consistent set of bits. After reset the line stays low until the block has seen the start of a frame and then reached a copy point.

Top module: `ctl_serial_out`

## Requirements
- R1: After reset `ctl_serial` is 0. It stays 0 until a copy edge that follows a tick with `chan_cnt`=0 and `slot_cnt`=0. The line is enabled from the tick after that copy edge and stays enabled.
- R2: Within a channel period, the tick with `slot_cnt`=s loads the bit of stream s. Slot 0 (stream 0) therefore goes out first and slot 7 (stream 7) last.
- R3: A tick with `chan_cnt`=c, where c<31, loads the live bit for channel c+1. The line holds that bit from the tick edge until the next tick edge.
- R4: A tick with `chan_cnt`=31 loads the live bit for channel 0 of the stream given by `slot_cnt`.
- R5: `ctl_serial` changes only at a clock edge where `bit_tick` is 1. At every other edge it keeps its value.
- R6: A write (`wr_en`=1) changes the pending bit at (`wr_stream`, `wr_chan`). The write reaches the serial line only after the next copy edge, which is the tick with `chan_cnt`=30 and `slot_cnt`=7. A write in the same cycle as a copy edge waits for the following copy edge.
- R7: A written bit persists: without further writes, the same bit is sent in every later frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse that starts each bit period |
| chan_cnt | input | 5 | Current channel of the frame (0..31) |
| slot_cnt | input | 3 | Current bit slot in the channel (0 = first) |
| wr_en | input | 1 | Write strobe for a control bit |
| wr_stream | input | 3 | Stream of the bit written |
| wr_chan | input | 5 | Channel of the bit written |
| wr_bit | input | 1 | Control bit value written |
| ctl_serial | output | 1 | Serial control line |

## Verification
The assertions check four things on every cycle: the line holds between ticks, it stays low while not enabled, the enable never drops once set, and a loaded bit equals the bit read from storage. They also check that a channel 31 tick reads channel 0. Only the bench scenarios can show that the read address picks the right stream and the next channel, and that writes are held back until the copy edge. This includes a write in the same cycle as the copy edge, and a reset in the middle of a frame that must wait for a full frame before the line is enabled.

// File: rtl/ctl_serial_pkg.sv
package ctl_serial_pkg;

  // Position of an entry in the flat bit image: stream-major order.
  function automatic int unsigned entry_index(int unsigned stream,
                                              int unsigned chan,
                                              int unsigned nchan);
    return stream * nchan + chan;
  endfunction

  // Channel that follows chan, wrapping at the end of the frame.
  function automatic int unsigned lookahead_chan(int unsigned chan,
                                                 int unsigned nchan);
    return (chan + 1 == nchan) ? 0 : chan + 1;
  endfunction

  // The copy point is the last slot of the channel before the last.
  function automatic bit is_copy_point(int unsigned chan, int unsigned slot,
                                       int unsigned nchan, int unsigned nslot);
    return (chan == nchan - 2) && (slot == nslot - 1);
  endfunction

endpackage

// File: rtl/cso_store.sv
module cso_store
  import ctl_serial_pkg::*;
#(
  parameter int NSTREAM = 8,
  parameter int NCHAN   = 32,
  parameter int SW      = $clog2(NSTREAM),
  parameter int CW      = $clog2(NCHAN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_stream,
  input  logic [CW-1:0] wr_chan,
  input  logic          wr_bit,
  input  logic          copy_evt,
  input  logic [SW-1:0] rd_stream,
  input  logic [CW-1:0] rd_chan,
  output logic          rd_bit
);
  localparam int NBITS = NSTREAM * NCHAN;

  logic [NBITS-1:0] pend_img;
  logic [NBITS-1:0] live_img;
  int unsigned wr_idx;
  int unsigned rd_idx;

  always_comb begin
    wr_idx = entry_index(int'(wr_stream), int'(wr_chan), NCHAN);
    rd_idx = entry_index(int'(rd_stream), int'(rd_chan), NCHAN);
  end

  for (genvar i = 0; i < NBITS; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_img[i] <= 1'b0;
        live_img[i] <= 1'b0;
      end else begin
        if (wr_en && wr_idx == i) pend_img[i] <= wr_bit;
        if (copy_evt) live_img[i] <= pend_img[i];
      end
    end
  end

  always_comb begin
    rd_bit = 1'b0;
    if (rd_idx < NBITS) rd_bit = live_img[rd_idx];
  end
endmodule

// File: rtl/cso_sched.sv
module cso_sched
  import ctl_serial_pkg::*;
#(
  parameter int NSTREAM = 8,
  parameter int NCHAN   = 32,
  parameter int SW      = $clog2(NSTREAM),
  parameter int CW      = $clog2(NCHAN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_tick,
  input  logic [CW-1:0] chan_cnt,
  input  logic [SW-1:0] slot_cnt,
  output logic [SW-1:0] rd_stream,
  output logic [CW-1:0] rd_chan,
  output logic          load_evt,
  output logic          copy_evt,
  output logic          wrap_evt,
  output logic          frame_start_evt,
  output logic          armed
);
  logic seen_start;

  always_comb begin
    load_evt        = bit_tick;
    rd_stream       = slot_cnt;
    rd_chan         = CW'(lookahead_chan(int'(chan_cnt), NCHAN));
    wrap_evt        = bit_tick && (int'(chan_cnt) == NCHAN - 1);
    frame_start_evt = bit_tick && chan_cnt == '0 && slot_cnt == '0;
    copy_evt        = bit_tick &&
                      is_copy_point(int'(chan_cnt), int'(slot_cnt), NCHAN, NSTREAM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_start <= 1'b0;
      armed      <= 1'b0;
    end else begin
      if (frame_start_evt) seen_start <= 1'b1;
      if (copy_evt && seen_start) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/cso_shift.sv
module cso_shift (
  input  logic clk,
  input  logic rst_n,
  input  logic load_evt,
  input  logic armed,
  input  logic rd_bit,
  output logic ctl_serial
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ctl_serial <= 1'b0;
    else if (load_evt) ctl_serial <= armed & rd_bit;
  end
endmodule

// File: rtl/ctl_serial_out.sv
module ctl_serial_out #(
  parameter int NSTREAM = 8,
  parameter int NCHAN   = 32,
  parameter int SW      = $clog2(NSTREAM),
  parameter int CW      = $clog2(NCHAN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_tick,
  input  logic [CW-1:0] chan_cnt,
  input  logic [SW-1:0] slot_cnt,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_stream,
  input  logic [CW-1:0] wr_chan,
  input  logic          wr_bit,
  output logic          ctl_serial
);
  logic [SW-1:0] rd_stream;
  logic [CW-1:0] rd_chan;
  logic          rd_bit;
  logic          load_evt;
  logic          copy_evt;
  logic          wrap_evt;
  logic          frame_start_evt;
  logic          armed;

  cso_sched #(.NSTREAM(NSTREAM), .NCHAN(NCHAN), .SW(SW), .CW(CW)) u_sched (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
    .chan_cnt(chan_cnt), .slot_cnt(slot_cnt),
    .rd_stream(rd_stream), .rd_chan(rd_chan),
    .load_evt(load_evt), .copy_evt(copy_evt), .wrap_evt(wrap_evt),
    .frame_start_evt(frame_start_evt), .armed(armed)
  );

  cso_store #(.NSTREAM(NSTREAM), .NCHAN(NCHAN), .SW(SW), .CW(CW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_stream(wr_stream), .wr_chan(wr_chan), .wr_bit(wr_bit),
    .copy_evt(copy_evt),
    .rd_stream(rd_stream), .rd_chan(rd_chan), .rd_bit(rd_bit)
  );

  cso_shift u_shift (
    .clk(clk), .rst_n(rst_n), .load_evt(load_evt), .armed(armed),
    .rd_bit(rd_bit), .ctl_serial(ctl_serial)
  );
endmodule

// File: rtl/ctl_serial_chk.sv
module ctl_serial_chk #(
  parameter int NCHAN = 32,
  parameter int CW    = $clog2(NCHAN)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_tick,
  input logic [CW-1:0] chan_cnt,
  input logic [CW-1:0] rd_chan,
  input logic          rd_bit,
  input logic          load_evt,
  input logic          armed,
  input logic          ctl_serial
);
  // R5
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(ctl_serial));

  // R1
  low_until_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !ctl_serial);

  // R1
  armed_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);

  // R3
  load_takes_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && armed) |=> (ctl_serial == $past(rd_bit)));

  // R4
  wrap_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && int'(chan_cnt) == NCHAN - 1) |-> (rd_chan == '0));
endmodule

bind ctl_serial_out ctl_serial_chk #(.NCHAN(NCHAN), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .chan_cnt(chan_cnt),
  .rd_chan(rd_chan), .rd_bit(rd_bit), .load_evt(load_evt),
  .armed(armed), .ctl_serial(ctl_serial)
);

// File: tb/sim_ctl_serial_out.sv
module sim_ctl_serial_out;
  localparam int NS = 8;
  localparam int NC = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0;
  logic [4:0] chan_cnt = '0;
  logic [2:0] slot_cnt = '0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_stream = '0;
  logic [4:0] wr_chan = '0;
  logic       wr_bit = 1'b0;
  logic       ctl_serial;

  ctl_serial_out u0 (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .chan_cnt(chan_cnt),
    .slot_cnt(slot_cnt), .wr_en(wr_en), .wr_stream(wr_stream),
    .wr_chan(wr_chan), .wr_bit(wr_bit), .ctl_serial(ctl_serial)
  );

  typedef struct packed { logic exp; logic [2:0] tag; } item_t;
  item_t q[$];

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit running = 0;
  int phase_tag = 3;

  bit pend_m[NS][NC];
  bit live_m[NS][NC];
  bit armed_m = 0;
  bit seen_m = 0;

  function automatic string tag_name(logic [2:0] t);
    case (t)
      3'd1: return "R1";
      3'd2: return "R2";
      3'd4: return "R4";
      3'd5: return "R5";
      3'd6: return "R6";
      3'd7: return "R7";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(bit ok, string req, logic act, logic exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // Driver: sets inputs for one clock and pushes the expected bit of a tick.
  task automatic drive(bit tk, int c, int s, bit we, int ws, int wc, bit wb);
    item_t it;
    int nc;
    @(negedge clk);
    bit_tick = tk; chan_cnt = 5'(c); slot_cnt = 3'(s);
    wr_en = we; wr_stream = 3'(ws); wr_chan = 5'(wc); wr_bit = wb;
    if (tk) begin
      nc = (c + 1) % NC;
      it.exp = armed_m ? live_m[s][nc] : 1'b0;
      if (!armed_m) it.tag = 3'd1;                          // R1
      else if (pend_m[s][nc] != live_m[s][nc]) it.tag = 3'd6; // R6 deferral
      else if (c == NC - 1) it.tag = 3'd4;                  // R4 wrap
      else it.tag = 3'(phase_tag);
      q.push_back(it);
      if (c == NC - 2 && s == NS - 1) begin
        live_m = pend_m;
        if (seen_m) armed_m = 1;
      end
      if (c == 0 && s == 0) seen_m = 1;
    end
    if (we) pend_m[ws][wc] = wb;
  endtask

  // One bit period: a tick plus three quiet cycles, with writes by mode.
  task automatic run_bit(int c, int s, int mode);
    int k;
    bit commit;
    commit = (c == NC - 2 && s == NS - 1);
    if (mode == 1 && commit)
      drive(1, c, s, 1, $urandom % NS, $urandom % NC, $urandom % 2); // R6 same-cycle write
    else
      drive(1, c, s, 0, 0, 0, 0);
    k = c * NS + s;
    if (mode == 1)
      drive(0, c, s, 1, $urandom % NS, $urandom % NC, $urandom % 2);
    else if (mode == 2)
      drive(0, c, s, 1, k / NC, k % NC, (k / NC) == ((k % NC) % NS)); // R2 pattern
    else
      drive(0, c, s, 0, 0, 0, 0);
    drive(0, c, s, 0, 0, 0, 0);
    drive(0, c, s, 0, 0, 0, 0);
  endtask

  // Monitor: pops an expected item after each tick edge, checks hold otherwise.
  bit saw_tick = 0;
  logic held = 1'b0;
  always @(posedge clk) saw_tick <= bit_tick;

  always @(negedge clk) begin
    if (running) begin
      if (saw_tick) begin
        if (q.size() == 0) begin
          chk(0, "R3", ctl_serial, 1'bx);
        end else begin
          item_t it;
          it = q.pop_front();
          chk(ctl_serial === it.exp, tag_name(it.tag), ctl_serial, it.exp);
        end
      end else begin
        chk(ctl_serial === held, "R5", ctl_serial, held);
      end
      held = ctl_serial;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ctl_serial === 1'b0, "R1", ctl_serial, 1'b0);
    held = ctl_serial;
    running = 1;
    // Partial frame after reset: the copy here must not enable the line (R1).
    for (int c = 20; c < NC; c++)
      for (int s = 0; s < NS; s++) run_bit(c, s, 1);
    for (int f = 0; f < 6; f++) begin
      int mode;
      case (f)
        2: begin mode = 2; phase_tag = 3; end
        3: begin mode = 0; phase_tag = 2; end // R2 one-hot pattern on view
        4: begin mode = 0; phase_tag = 7; end // R7 unchanged bits repeat
        default: begin mode = 1; phase_tag = 3; end
      endcase
      for (int c = 0; c < NC; c++)
        for (int s = 0; s < NS; s++) run_bit(c, s, mode);
    end
    drive(0, 0, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    chk(q.size() == 0, "R3", 1'(q.size() != 0), 1'b0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule